// File: doc/BRIEF.md
# CRC-32 Residue Finisher (fold and Barrett reduce)

This block takes the 128-bit residue that an upstream folding stage has built for an MSB-first CRC-32 over the generator 0x04C11DB7. It turns that residue into the final 32-bit remainder. Two constant carry-less multiplies shrink the residue: first to 96 bits, then to 64 bits. A Barrett reduction, which is two more constant carry-less multiplies, then yields the exact remainder. No serial divider is used.

The block is a four-stage pipeline. A new residue may be presented with `in_valid` on every clock. Each result comes out with `out_valid` a fixed number of cycles later, in the order the residues went in. Final inversion, bit reflection and the folding of message data are done elsewhere.

Top module: `crcfin_top`

## Requirements
- R1: While `rst_n` is low and on the first cycles after reset, `out_valid` is 0 and `out_crc` is 0.
- R2: For an accepted residue V, `out_crc` equals V·x^32 mod 0x104C11DB7. This is the CRC of the 128 bits fed MSB-first (bit 127 first), with a zero initial value and no inversion or reflection.
- R3: A residue sampled with `in_valid`=1 on a rising edge gives `out_valid`=1 during the cycle after the fourth rising edge, counting that edge as the first. `out_crc` carries the result in that same cycle.
- R4: Residues accepted on consecutive cycles produce results on consecutive cycles, in the order of acceptance, each still correct.
- R5: When `in_valid` is 0, `in_residue` is ignored. No `out_valid` pulse follows, and `out_crc` keeps its last value while `out_valid` is 0.
- R6: A residue of all zeros yields a CRC of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Residue on `in_residue` is to be reduced |
| in_residue | input | 128 | Folded 128-bit residue, bit 127 most significant |
| out_valid | output | 1 | `out_crc` holds a new result this cycle |
| out_crc | output | 32 | Reduced 32-bit CRC remainder |

## Verification
Two things can land in the same cycle: a new residue being accepted and an earlier result leaving the last stage. The same clash happens inside, where every stage loads new work while handing its old work on. The bench drives long back-to-back bursts, so that acceptance and delivery overlap in every cycle. It also drives residues with single bits set at both ends, which separates the two fold terms. Each result is judged against a bit-serial LFSR model over the same 128 bits, and each result must arrive exactly four cycles after its issue cycle. Idle gaps are driven with garbage on the data input, and during those gaps the output must not move.

// File: rtl/crcfin_pkg.sv
package crcfin_pkg;
    localparam int CRC_W   = 32;
    localparam int CONST_W = CRC_W + 1;
    localparam int IN_W    = 4 * CRC_W;
    localparam int MID_W   = 3 * CRC_W;
    localparam int RED_W   = 2 * CRC_W;

    // x^96 mod P, x^64 mod P, floor(x^64 / P), and P with its top term
    localparam logic [CONST_W-1:0] K_FOLD96 = 33'h0F200AA66;
    localparam logic [CONST_W-1:0] K_FOLD64 = 33'h0490D678D;
    localparam logic [CONST_W-1:0] K_MU     = 33'h104D101DF;
    localparam logic [CONST_W-1:0] K_GEN    = 33'h104C11DB7;

    typedef struct packed {
        logic             s1_v;
        logic [MID_W-1:0] s1_acc;
        logic             s2_v;
        logic [RED_W-1:0] s2_rem;
        logic             s3_v;
        logic [CRC_W-1:0] s3_rlo;
        logic [CRC_W-1:0] s3_quot;
        logic             o_v;
        logic [CRC_W-1:0] o_crc;
    } pipe_t;
endpackage

// File: rtl/crcfin_clmul.sv
// Carry-less multiply of a variable operand by a constant. Only the output
// bits [LO +: OW] of the product are built.
module crcfin_clmul #(
    parameter int AW = 32,
    parameter int KW = 33,
    parameter logic [KW-1:0] K = '0,
    parameter int LO = 0,
    parameter int OW = 32
) (
    input  logic [AW-1:0] a,
    output logic [OW-1:0] p
);
    for (genvar gk = 0; gk < OW; gk++) begin : g_bit
        logic [KW-1:0] term;
        for (genvar gi = 0; gi < KW; gi++) begin : g_term
            localparam int J = gk + LO - gi;
            if (K[gi] && J >= 0 && J < AW) begin : g_on
                assign term[gi] = a[J];
            end else begin : g_off
                assign term[gi] = 1'b0;
            end
        end
        assign p[gk] = ^term;
    end
endmodule

// File: rtl/crcfin_fold128.sv
// 128 -> 96 bit fold: high half times x^96 mod P, low half times x^32.
module crcfin_fold128
    import crcfin_pkg::*;
(
    input  logic [IN_W-1:0]  res,
    output logic [MID_W-1:0] acc
);
    logic [MID_W-1:0] hi_prod;

    crcfin_clmul #(
        .AW(RED_W), .KW(CONST_W), .K(K_FOLD96), .LO(0), .OW(MID_W)
    ) u_mul (
        .a(res[IN_W-1:RED_W]),
        .p(hi_prod)
    );

    assign acc = hi_prod ^ {res[RED_W-1:0], {CRC_W{1'b0}}};
endmodule

// File: rtl/crcfin_top.sv
module crcfin_top
    import crcfin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_residue,
    output logic             out_valid,
    output logic [CRC_W-1:0] out_crc
);
    pipe_t state_d, state_q;

    logic [MID_W-1:0] fold96_w;
    logic [RED_W-1:0] fold64_w;
    logic [CRC_W-1:0] quot_w;
    logic [CRC_W-1:0] corr_w;

    // stage 1: 128 -> 96
    crcfin_fold128 u_fold (
        .res(in_residue),
        .acc(fold96_w)
    );

    // stage 2: 96 -> 64, upper word times x^64 mod P
    crcfin_clmul #(
        .AW(CRC_W), .KW(CONST_W), .K(K_FOLD64), .LO(0), .OW(RED_W)
    ) u_fold64 (
        .a(state_q.s1_acc[MID_W-1:RED_W]),
        .p(fold64_w)
    );

    // stage 3: quotient estimate, upper half of (R >> 32) times mu
    crcfin_clmul #(
        .AW(CRC_W), .KW(CONST_W), .K(K_MU), .LO(CRC_W), .OW(CRC_W)
    ) u_mu (
        .a(state_q.s2_rem[RED_W-1:CRC_W]),
        .p(quot_w)
    );

    // stage 4: correction, low half of quotient times generator
    crcfin_clmul #(
        .AW(CRC_W), .KW(CONST_W), .K(K_GEN), .LO(0), .OW(CRC_W)
    ) u_gen (
        .a(state_q.s3_quot),
        .p(corr_w)
    );

    always_comb begin
        state_d = state_q;

        state_d.s1_v = in_valid;
        if (in_valid) begin
            state_d.s1_acc = fold96_w;
        end

        state_d.s2_v = state_q.s1_v;
        if (state_q.s1_v) begin
            state_d.s2_rem = fold64_w ^ state_q.s1_acc[RED_W-1:0];
        end

        state_d.s3_v = state_q.s2_v;
        if (state_q.s2_v) begin
            state_d.s3_rlo  = state_q.s2_rem[CRC_W-1:0];
            state_d.s3_quot = quot_w;
        end

        state_d.o_v = state_q.s3_v;
        if (state_q.s3_v) begin
            state_d.o_crc = state_q.s3_rlo ^ corr_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.o_v;
    assign out_crc   = state_q.o_crc;
endmodule

// File: rtl/crcfin_chk.sv
module crcfin_chk
    import crcfin_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_residue,
    input logic             out_valid,
    input logic [CRC_W-1:0] out_crc
);
    logic [2:0] since_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 3'd7) begin
            since_rst_q <= since_rst_q + 3'd1;
        end
    end

    // R1: no result can leave before four edges have passed since reset
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q < 3'd4) |-> (!out_valid && out_crc == '0));

    // R3: accepted residue yields a result four edges later
    assert_latency_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##4 out_valid);

    // R5: no result without an accepted residue four edges earlier
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 3'd4 && out_valid) |-> $past(in_valid, 4));

    // R5: output holds while no result is presented
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 3'd1 && !out_valid) |-> $stable(out_crc));

    // R6: zero residue reduces to zero
    assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_residue == '0) |-> ##4 (out_crc == '0));
endmodule

bind crcfin_top crcfin_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(in_valid),
    .in_residue(in_residue),
    .out_valid(out_valid),
    .out_crc(out_crc)
);

// File: tb/sim_crcfin_top.sv
`timescale 1ns/1ps
module sim_crcfin_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_residue = '0;
    logic         out_valid;
    logic [31:0]  out_crc;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    int          cyc_q[$];
    string       tag_q[$];
    logic [31:0] last_crc = '0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    crcfin_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_residue(in_residue), .out_valid(out_valid), .out_crc(out_crc)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // bit-serial MSB-first LFSR over the 128 residue bits, zero start
    function automatic logic [31:0] ref_crc(input logic [127:0] m);
        logic [31:0] c;
        logic fb;
        c = '0;
        for (int i = 127; i >= 0; i--) begin
            fb = c[31] ^ m[i];
            c = c << 1;
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    function automatic logic [63:0] step(input logic [63:0] s);
        logic [63:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [127:0] v, input string tag);
        @(negedge clk);
        in_valid   = 1'b1;
        in_residue = v;
        exp_q.push_back(ref_crc(v));
        cyc_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            rng = step(rng);
            in_residue = {rng, ~rng};
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // monitor: compare results as they leave the design
    initial begin
        logic [31:0] e;
        int          c0;
        string       t;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5 unexpected out_valid", out_crc, last_crc);
                    end else begin
                        e = exp_q.pop_front();
                        c0 = cyc_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_crc == e, {t, " R2 crc value"}, out_crc, e);
                        check(cyc - c0 == 4, "R3 latency", 32'(cyc - c0), 32'd4);
                    end
                    last_crc = out_crc;
                end else begin
                    check(out_crc == last_crc, "R5 hold while idle", out_crc, last_crc);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        in_residue = 128'hDEADBEEF_0BADF00D_CAFEF00D_12345678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        check(out_crc == '0, "R1 out_crc in reset", out_crc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

        // single-shot patterns
        send('0, "R6 zero");
        idle(6);
        send({1'b1, 127'd0}, "R2 top bit");
        idle(6);
        send(128'd1, "R2 bottom bit");
        idle(6);
        send({64'd0, {64{1'b1}}}, "R2 low half");
        idle(6);
        send({{64{1'b1}}, 64'd0}, "R2 high half");
        idle(6);
        send({128{1'b1}}, "R2 all ones");
        idle(6);

        // back-to-back burst: accept and deliver in the same cycles
        for (int k = 0; k < 40; k++) begin
            rng = step(rng);
            send({rng, step(rng)}, "R4 burst");
        end
        idle(3);
        // garbage on data with in_valid low: must not emit
        idle(12);
        for (int k = 0; k < 20; k++) begin
            rng = step(rng);
            if (k % 3 == 0) begin
                send('0, "R6 zero in burst");
            end else begin
                send({step(rng), rng}, "R4 mixed burst");
            end
            if (k % 5 == 4) idle(1);
        end
        idle(10);
        check(exp_q.size() == 0, "R4 all results delivered",
              32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule